// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block performs 16-bit multiplication and division, signed or unsigned, and returns every result as a pair of 16-bit words in a fixed order. The order suits a result stream that takes two values per operation. A two-bit opcode picks the operation. A multiply returns the low half of the 32-bit product, then the high half. A divide returns the quotient, then the remainder.

The unit is iterative and retires one bit of work per clock. A caller raises `start_i` for one cycle with the opcode and operands. The unit raises `busy_o` and ignores further starts until it finishes. It then pulses `done_o` for one cycle, and both result words are valid in that cycle. The result words stay unchanged until the next completion.

The unit has no flag output and never traps. Division by zero returns a defined result, and so does the one signed quotient that overflows.

Top module: `muldiv_unit`

## Requirements
- R1: Opcode 2'b01 (unsigned multiply) treats both operands as unsigned; `res_first_o` is bits 15:0 of the 32-bit product and `res_second_o` is bits 31:16.
- R2: Opcode 2'b00 (signed multiply) treats both operands as two's complement; `res_first_o` is bits 15:0 of the signed 32-bit product and `res_second_o` is bits 31:16.
- R3: Opcode 2'b11 (unsigned divide) returns the unsigned quotient on `res_first_o` and the unsigned remainder on `res_second_o`.
- R4: Opcode 2'b10 (signed divide) truncates the quotient toward zero, and the remainder carries the sign of the dividend; quotient on `res_first_o`, remainder on `res_second_o`.
- R5: For either divide opcode with a zero divisor, the quotient is 0 and the remainder equals the dividend, bit for bit.
- R6: A signed divide of 16'h8000 by 16'hFFFF returns quotient 16'h8000 and remainder 0.
- R7: `done_o` is high for exactly one cycle. It rises after the 18th rising edge (WIDTH+2) counted from, and including, the edge that samples `start_i`.
- R8: `busy_o` is high from the edge that accepts a start through the `done_o` cycle, and low in the following cycle. A `start_i` seen while `busy_o` is high has no effect on the running operation or its results.
- R9: While `rst_n` is low, `busy_o`, `done_o` and both result words are 0.
- R10: Both result words stay unchanged at all times except at the edge that brings `done_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request an operation; sampled only while idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | 16 | Multiplicand or dividend |
| b_i | input | 16 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe: result words valid |
| res_first_o | output | 16 | Product low word or quotient |
| res_second_o | output | 16 | Product high word or remainder |

## Verification
The directed cases target the points where a magnitude datapath goes wrong. A signed product of two most-negative operands has a high word of 16'h4000 and would read 16'hC000 if the final negation were applied wrongly. Divides of mixed sign, such as -7/2 and 7/-2, would give a floored quotient or a remainder with the wrong sign if truncation were mishandled. A zero divisor would produce an all-ones quotient from a plain restoring loop. For the signed 16'h8000/16'hFFFF case, any range clamp would break the 16'h8000 quotient. The bench also fires a second start in the middle of an operation, and counts edges to the strobe, to expose off-by-one iteration counts and starts that are not ignored.

// File: rtl/muldiv_pkg.sv
// Package: shared opcode and sequencer state types for the multiply/divide unit.
// Assumes: opcode bit 1 selects divide, bit 0 selects unsigned arithmetic.
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_UMUL = 2'b01,
        OP_DIV  = 2'b10,
        OP_UDIV = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIX  = 2'b10,
        ST_DONE = 2'b11
    } md_state_e;

endpackage

// File: rtl/muldiv_sign_prep.sv
// Module: muldiv_sign_prep
// Turns raw operands into magnitudes and records the result signs.
// Assumes: op[0]=1 means unsigned, so no magnitude conversion is done.
// The most negative value maps to its unsigned magnitude (2^(W-1)).
module muldiv_sign_prep #(
    parameter int W = 16
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_main,
    output logic         neg_rem,
    output logic         div_zero
);
    logic is_signed;
    logic a_neg;
    logic b_neg;

    // Decide operand signs and strip them.
    always_comb begin
        is_signed = ~op[0];
        a_neg     = is_signed & a[W-1];
        b_neg     = is_signed & b[W-1];
        mag_a     = a_neg ? (~a + 1'b1) : a;
        mag_b     = b_neg ? (~b + 1'b1) : b;
        neg_main  = a_neg ^ b_neg;
        neg_rem   = a_neg;
        div_zero  = (b == '0);
    end
endmodule

// File: rtl/muldiv_mul_step.sv
// Module: muldiv_mul_step
// One shift-add multiply iteration on the unsigned {hi, lo} accumulator.
// Assumes: lo starts with the multiplier, hi with zero; after W steps
// {hi[W-1:0], lo} holds the full product of the two magnitudes.
module muldiv_mul_step #(
    parameter int W = 16
) (
    input  logic [W:0]   hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] mcand,
    output logic [W:0]   hi_out,
    output logic [W-1:0] lo_out
);
    logic [W:0] sum;

    // Add the multiplicand when the current multiplier bit is set, then shift right.
    always_comb begin
        sum    = {1'b0, hi_in[W-1:0]} + (lo_in[0] ? {1'b0, mcand} : '0);
        hi_out = {1'b0, sum[W:1]};
        lo_out = {sum[0], lo_in[W-1:1]};
    end
endmodule

// File: rtl/muldiv_div_step.sv
// Module: muldiv_div_step
// One restoring-division iteration: shift in a dividend bit, trial-subtract.
// Assumes: lo starts with the dividend magnitude and hi with zero; after W steps
// lo is the quotient and hi[W-1:0] the remainder (for a nonzero divisor).
module muldiv_div_step #(
    parameter int W = 16
) (
    input  logic [W:0]   hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] divisor,
    output logic [W:0]   hi_out,
    output logic [W-1:0] lo_out
);
    logic [W:0]   shifted;
    logic [W+1:0] trial;
    logic         fits;

    // Keep the difference only when the divisor fits the partial remainder.
    always_comb begin
        shifted = {hi_in[W-1:0], lo_in[W-1]};
        trial   = {1'b0, shifted} - {2'b00, divisor};
        fits    = ~trial[W+1];
        hi_out  = fits ? trial[W:0] : shifted;
        lo_out  = {lo_in[W-2:0], fits};
    end
endmodule

// File: rtl/muldiv_result_fix.sv
// Module: muldiv_result_fix
// Applies signs to the magnitude result and orders the two output words.
// Assumes: the sign flags come from muldiv_sign_prep for the same operation;
// a zero divisor overrides the loop result with the raw dividend.
module muldiv_result_fix #(
    parameter int W = 16
) (
    input  logic [1:0]   op,
    input  logic [W:0]   hi,
    input  logic [W-1:0] lo,
    input  logic         neg_main,
    input  logic         neg_rem,
    input  logic         div_zero,
    input  logic [W-1:0] dividend_raw,
    output logic [W-1:0] word_first,
    output logic [W-1:0] word_second
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;

    // Select product halves or quotient/remainder, applying negation.
    always_comb begin
        prod = {hi[W-1:0], lo};
        if (neg_main) prod = ~prod + 1'b1;
        quo  = neg_main ? (~lo + 1'b1) : lo;
        rem  = neg_rem ? (~hi[W-1:0] + 1'b1) : hi[W-1:0];
        if (!op[1]) begin
            word_first  = prod[W-1:0];
            word_second = prod[PW-1:W];
        end else if (div_zero) begin
            word_first  = '0;
            word_second = dividend_raw;
        end else begin
            word_first  = quo;
            word_second = rem;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
// Module: muldiv_unit (top)
// Iterative signed/unsigned multiply and divide, one bit per clock.
// Sequence: accept start while idle, W iteration cycles, one sign-fix cycle,
// one done cycle. Results are registered and held until the next completion.
// Assumes: synchronous active-low reset; start is ignored while busy.
module muldiv_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] res_first_o,
    output logic [W-1:0] res_second_o
);
    import muldiv_pkg::*;

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    md_state_e    state_q;
    logic [CW-1:0] step_q;
    logic [1:0]   op_q;
    logic [W:0]   hi_q;
    logic [W-1:0] lo_q;
    logic [W-1:0] opnd_q;
    logic [W-1:0] a_raw_q;
    logic         neg_main_q;
    logic         neg_rem_q;
    logic         div_zero_q;
    logic [W-1:0] res_first_q;
    logic [W-1:0] res_second_q;

    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    logic         neg_main_d;
    logic         neg_rem_d;
    logic         div_zero_d;
    logic [W:0]   mul_hi;
    logic [W-1:0] mul_lo;
    logic [W:0]   div_hi;
    logic [W-1:0] div_lo;
    logic [W-1:0] fix_first;
    logic [W-1:0] fix_second;

    muldiv_sign_prep #(.W(W)) u_prep (
        .op       (op_i),
        .a        (a_i),
        .b        (b_i),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_main (neg_main_d),
        .neg_rem  (neg_rem_d),
        .div_zero (div_zero_d)
    );

    muldiv_mul_step #(.W(W)) u_mul (
        .hi_in  (hi_q),
        .lo_in  (lo_q),
        .mcand  (opnd_q),
        .hi_out (mul_hi),
        .lo_out (mul_lo)
    );

    muldiv_div_step #(.W(W)) u_div (
        .hi_in   (hi_q),
        .lo_in   (lo_q),
        .divisor (opnd_q),
        .hi_out  (div_hi),
        .lo_out  (div_lo)
    );

    muldiv_result_fix #(.W(W)) u_fix (
        .op           (op_q),
        .hi           (hi_q),
        .lo           (lo_q),
        .neg_main     (neg_main_q),
        .neg_rem      (neg_rem_q),
        .div_zero     (div_zero_q),
        .dividend_raw (a_raw_q),
        .word_first   (fix_first),
        .word_second  (fix_second)
    );

    // Sequencer and datapath registers: load, iterate, fix signs, strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            step_q       <= '0;
            op_q         <= '0;
            hi_q         <= '0;
            lo_q         <= '0;
            opnd_q       <= '0;
            a_raw_q      <= '0;
            neg_main_q   <= 1'b0;
            neg_rem_q    <= 1'b0;
            div_zero_q   <= 1'b0;
            res_first_q  <= '0;
            res_second_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q       <= op_i;
                        a_raw_q    <= a_i;
                        neg_main_q <= neg_main_d;
                        neg_rem_q  <= neg_rem_d;
                        div_zero_q <= div_zero_d;
                        hi_q       <= '0;
                        lo_q       <= op_i[1] ? mag_a : mag_b;
                        opnd_q     <= op_i[1] ? mag_b : mag_a;
                        step_q     <= '0;
                        state_q    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    hi_q   <= op_q[1] ? div_hi : mul_hi;
                    lo_q   <= op_q[1] ? div_lo : mul_lo;
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    res_first_q  <= fix_first;
                    res_second_q <= fix_second;
                    state_q      <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from sequencer state.
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = (state_q == ST_DONE);
        res_first_o  = res_first_q;
        res_second_o = res_second_q;
    end
endmodule

// File: rtl/muldiv_unit_chk.sv
// Module: muldiv_unit_chk
// Protocol checker bound to muldiv_unit: strobe width, busy coverage,
// latency (counted, not unrolled) and result hold.
module muldiv_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] res_first_o,
    input logic [W-1:0] res_second_o
);
    localparam int LW = $clog2(W + 4) + 1;

    logic [LW-1:0] since_start;

    // Count edges since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) since_start <= '0;
        else if (start_i && !busy_o) since_start <= '0;
        else if (busy_o) since_start <= since_start + 1'b1;
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_start == LW'(W + 1)));

    assert_done_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_start_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(res_first_o) && $stable(res_second_o)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .res_first_o  (res_first_o),
    .res_second_o (res_second_o)
);

// File: tb/sim_muldiv_unit.sv
// Bench for muldiv_unit: directed corners plus seeded random operations,
// compared against reference functions computed here.
module sim_muldiv_unit;
    localparam int W   = 16;
    localparam int LAT = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] res_first_o;
    logic [W-1:0] res_second_o;

    int n_vec  = 0;
    int n_fail = 0;
    logic [W-1:0] last_first  = '0;
    logic [W-1:0] last_second = '0;

    always #10 clk = ~clk;

    muldiv_unit #(.W(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_i         (op_i),
        .a_i          (a_i),
        .b_i          (b_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .res_first_o  (res_first_o),
        .res_second_o (res_second_o)
    );

    // Reference: returns {second, first}.
    function automatic logic [31:0] model(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] sa, sb, q, r;
        logic [31:0] p;
        sa = {{16{a[15]}}, a};
        sb = {{16{b[15]}}, b};
        case (op)
            2'b00: begin p = sa * sb; return p; end
            2'b01: begin p = {16'h0, a} * {16'h0, b}; return p; end
            2'b11: begin
                if (b == 0) return {a, 16'h0};
                return {a % b, a / b};
            end
            default: begin
                if (b == 0) return {a, 16'h0};
                q = sa / sb;
                r = sa % sb;
                return {r[15:0], q[15:0]};
            end
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
        if (op[1] && b == 0) return "R5";
        if (op == 2'b10 && a == 16'h8000 && b == 16'hFFFF) return "R6";
        case (op)
            2'b00: return "R2";
            2'b01: return "R1";
            2'b10: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation; poke=1 fires a second start while busy.
    task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b, input bit poke);
        int n;
        bit got;
        logic [31:0] exp;
        string req;
        exp = model(op, a, b);
        req = req_of(op, a, b);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; start_i = 1'b1;
        n = 0; got = 0;
        while (!got && n < 40) begin
            @(posedge clk); #1;
            n++;
            if (n == 1) begin
                start_i = 1'b0;
                chk("R8", {31'b0, busy_o}, 32'd1);
            end
            if (n == 3) chk("R10", {res_second_o, res_first_o}, {last_second, last_first});
            if (poke && n == 5) begin
                start_i = 1'b1; a_i = ~a; b_i = b + 16'd3; op_i = op ^ 2'b01;
            end
            if (poke && n == 6) start_i = 1'b0;
            if (done_o) got = 1;
        end
        chk("R7", n, LAT);
        chk(poke ? "R8" : req, {res_second_o, res_first_o}, exp);
        @(posedge clk); #1;
        chk("R7", {31'b0, done_o}, 32'd0);
        chk("R8", {31'b0, busy_o}, 32'd0);
        repeat (2) @(posedge clk);
        #1;
        chk("R10", {res_second_o, res_first_o}, exp);
        last_first  = res_first_o;
        last_second = res_second_o;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1;
        chk("R9", {29'b0, busy_o, done_o, 1'b0}, 32'd0);
        chk("R9", {res_second_o, res_first_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed corners
        run_op(2'b01, 16'hFFFF, 16'hFFFF, 0);   // R1
        run_op(2'b00, 16'h8000, 16'h8000, 0);   // R2
        run_op(2'b00, 16'hFFFF, 16'h0003, 0);   // R2
        run_op(2'b00, 16'h1234, 16'h0000, 0);   // R2
        run_op(2'b11, 16'h8000, 16'hFFFF, 0);   // R3
        run_op(2'b11, 16'd100, 16'd7, 0);       // R3
        run_op(2'b10, 16'hFFF9, 16'd2, 0);      // R4: -7/2
        run_op(2'b10, 16'd7, 16'hFFFE, 0);      // R4: 7/-2
        run_op(2'b10, 16'hFFF9, 16'hFFFE, 0);   // R4
        run_op(2'b10, 16'hC123, 16'h0000, 0);   // R5
        run_op(2'b11, 16'hC123, 16'h0000, 0);   // R5
        run_op(2'b10, 16'h8000, 16'hFFFF, 0);   // R6
        run_op(2'b00, 16'h7FFF, 16'h8000, 1);   // R8 start while busy
        run_op(2'b10, 16'hB00B, 16'h0013, 1);   // R8

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [1:0]  op;
            logic [15:0] a, b;
            op = 2'($urandom);
            a  = 16'($urandom);
            b  = 16'($urandom);
            if (($urandom % 8) == 0) b = 16'($urandom % 4);
            if (($urandom % 16) == 0) a = 16'h8000;
            run_op(op, a, b, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule